// File: doc/BRIEF.md
# Hysteretic Digital Lock Detector

This block judges whether a phase-locked loop has settled by timing the gap between the divided reference edge and the divided feedback edge on every phase-detector cycle. Both edges arrive as single-cycle strobes synchronous to a fast sampling clock, and the gap is counted in periods of that clock. The result goes through a hysteresis rule. Lock is declared only after a programmable run of consecutive tight cycles. It is withdrawn only when one cycle is clearly off, so the small jitter of a settled loop does not toggle the flag.

A precision input selects the shorter or the longer qualifying run. A power-down input clears the detector. A mute enable holds the RF output enable low until lock is reported, so a downstream output stage stays silent while the loop is still slewing.

Top module: `phase_lock_watch`

## Requirements
- R1: After reset, `lock` is 0. `lock` is an active-high flag.
- R2: With `precise` = 0, `lock` rises after three consecutive cycles whose error is below `LOCK_BELOW` counts (default 3). It rises on the clock edge that samples the third cycle's closing strobe.
- R3: With `precise` = 1, five consecutive such cycles are needed before `lock` rises.
- R4: Once `lock` is 1, it stays 1 through cycles whose error is at most `UNLOCK_ABOVE` counts (default 5). It falls on the first cycle whose error exceeds that value.
- R5: If the second strobe has not come within `SAT_CNT` counts (default 63) of the first, the cycle counts as bad. A locked detector then drops `lock`.
- R6: While unlocked, a cycle whose error is neither good nor bad (3 to 5 counts by default) restarts the run of good cycles from zero.
- R7: The error is the count from whichever strobe comes first to the other strobe. Either order is measured the same way. Strobes in the same sampling cycle give an error of 0.
- R8: While `pwr_down` is 1, `lock` is 0 and the run of good cycles is cleared. After release, a full new run is needed.
- R9: With `mute_en` = 1, `rf_en` is 1 only when `lock` is 1 and `pwr_down` is 0.
- R10: With `mute_en` = 0, `rf_en` equals the inverse of `pwr_down`, whatever the state of `lock`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock; it sets the error resolution |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_stb | input | 1 | One-cycle strobe at each divided reference edge |
| fb_stb | input | 1 | One-cycle strobe at each divided feedback edge |
| precise | input | 1 | 0: three good cycles to lock; 1: five |
| pwr_down | input | 1 | Synchronous clear of the detector; also gates `rf_en` |
| mute_en | input | 1 | Holds `rf_en` low until locked |
| lock | output | 1 | Active-high lock flag |
| rf_en | output | 1 | RF output enable |

## Verification
The hardest state to reach is a run of good cycles that is partly complete and then cut short. This happens either by a middle-band cycle or by power-down. From outside, it shows only as a later delay in `lock` rising. The stimulus therefore builds a partial run, then inserts the interruption, then counts how many further good cycles are needed before the flag rises. The saturation path is reached by sending a reference strobe with no feedback strobe and idling past the limit while locked.

// File: rtl/phase_lock_watch.sv
module phase_lock_watch #(
  parameter int SAT_CNT      = 63,
  parameter int LOCK_BELOW   = 3,
  parameter int UNLOCK_ABOVE = 5,
  parameter int RUN_SHORT    = 3,
  parameter int RUN_LONG     = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_stb,
  input  logic fb_stb,
  input  logic precise,
  input  logic pwr_down,
  input  logic mute_en,
  output logic lock,
  output logic rf_en
);
  localparam int CW = $clog2(SAT_CNT + 1);
  localparam int RW = $clog2(RUN_LONG + 1);
  localparam logic [CW-1:0] SAT_V = CW'(SAT_CNT);
  localparam logic [CW-1:0] LB_V  = CW'(LOCK_BELOW);
  localparam logic [CW-1:0] UA_V  = CW'(UNLOCK_ABOVE);

  typedef enum logic [1:0] {S_IDLE, S_REF, S_FB} st_t;

  st_t         st;
  logic [CW-1:0] cnt;
  logic [RW-1:0] run;
  logic          meas_done, meas_sat, meas_good, meas_bad;
  logic [CW-1:0] meas_err;
  logic [RW-1:0] need;

  always_comb begin
    meas_done = 1'b0;
    meas_sat  = 1'b0;
    meas_err  = '0;
    case (st)
      S_IDLE: if (ref_stb && fb_stb) meas_done = 1'b1;
      S_REF: begin
        if (fb_stb) begin meas_done = 1'b1; meas_err = cnt; end
        else if (cnt == SAT_V) meas_sat = 1'b1;
      end
      S_FB: begin
        if (ref_stb) begin meas_done = 1'b1; meas_err = cnt; end
        else if (cnt == SAT_V) meas_sat = 1'b1;
      end
      default: ;
    endcase
  end

  assign meas_good = meas_done && (meas_err < LB_V);
  assign meas_bad  = meas_sat || (meas_done && (meas_err > UA_V));
  assign need      = precise ? RW'(RUN_LONG) : RW'(RUN_SHORT);
  assign rf_en     = !pwr_down && (!mute_en || lock);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else if (pwr_down) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (ref_stb ^ fb_stb) begin
          st  <= ref_stb ? S_REF : S_FB;
          cnt <= CW'(1);
        end
        default: if (meas_done || meas_sat) begin
          st  <= S_IDLE;
          cnt <= '0;
        end else begin
          cnt <= cnt + CW'(1);
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock <= 1'b0;
      run  <= '0;
    end else if (pwr_down) begin
      lock <= 1'b0;
      run  <= '0;
    end else if (lock) begin
      if (meas_bad) lock <= 1'b0;
      run <= '0;
    end else if (meas_good) begin
      if (run == need - RW'(1)) begin
        lock <= 1'b1;
        run  <= '0;
      end else begin
        run <= run + RW'(1);
      end
    end else if (meas_done || meas_sat) begin
      run <= '0;
    end
  end
endmodule

// File: rtl/phase_lock_watch_chk.sv
module phase_lock_watch_chk (
  input logic clk,
  input logic rst_n,
  input logic pwr_down,
  input logic mute_en,
  input logic lock,
  input logic rf_en,
  input logic bad_seen
);
  AST_PD_CLEARS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> !lock); // R8
  AST_NO_RISE_IN_PD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> !$past(pwr_down)); // R8
  AST_DROP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock) |-> ($past(pwr_down) || $past(bad_seen))); // R4
  AST_MUTE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_en && !lock) |-> !rf_en); // R9
  AST_PD_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> !rf_en); // R10
  AST_UNMUTED_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (!mute_en && !pwr_down) |-> rf_en); // R10
endmodule

bind phase_lock_watch phase_lock_watch_chk i_chk (
  .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .mute_en(mute_en),
  .lock(lock), .rf_en(rf_en), .bad_seen(meas_bad)
);

// File: tb/test_phase_lock_watch.sv
module test_phase_lock_watch;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_stb = 1'b0, fb_stb = 1'b0, precise = 1'b0, pwr_down = 1'b0, mute_en = 1'b1;
  logic lock, rf_en;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  phase_lock_watch i_phase_lock_watch (
    .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb), .fb_stb(fb_stb),
    .precise(precise), .pwr_down(pwr_down), .mute_en(mute_en),
    .lock(lock), .rf_en(rf_en)
  );

  // {expected lock, precise, feedback first, error[5:0]}
  localparam int NV = 18;
  localparam logic [8:0] VEC [NV] = '{
    {1'b0,1'b0,1'b0,6'd1}, {1'b0,1'b0,1'b0,6'd2}, {1'b1,1'b0,1'b0,6'd0},
    {1'b1,1'b0,1'b0,6'd5}, {1'b1,1'b0,1'b1,6'd4}, {1'b0,1'b0,1'b0,6'd6},
    {1'b0,1'b0,1'b1,6'd2}, {1'b0,1'b0,1'b1,6'd1}, {1'b0,1'b0,1'b0,6'd4},
    {1'b0,1'b0,1'b0,6'd1}, {1'b0,1'b0,1'b0,6'd1}, {1'b1,1'b0,1'b0,6'd2},
    {1'b0,1'b0,1'b1,6'd9}, {1'b0,1'b1,1'b0,6'd1}, {1'b0,1'b1,1'b0,6'd1},
    {1'b0,1'b1,1'b1,6'd1}, {1'b0,1'b1,1'b0,6'd2}, {1'b1,1'b1,1'b0,6'd2}
  };

  task automatic check(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic pd_cycle(input logic fb_first, input int err);
    @(negedge clk);
    if (err == 0) begin ref_stb = 1'b1; fb_stb = 1'b1; end
    else if (fb_first) fb_stb = 1'b1;
    else ref_stb = 1'b1;
    @(negedge clk);
    ref_stb = 1'b0; fb_stb = 1'b0;
    if (err > 0) begin
      repeat (err - 1) @(negedge clk);
      if (fb_first) ref_stb = 1'b1; else fb_stb = 1'b1;
      @(negedge clk);
      ref_stb = 1'b0; fb_stb = 1'b0;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(4 * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(lock, 1'b0, "R1 lock low in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(lock, 1'b0, "R1 lock low after reset");
    check(rf_en, 1'b0, "R9 muted after reset");

    for (int i = 0; i < NV; i++) begin
      precise = VEC[i][7];
      pd_cycle(VEC[i][6], int'(VEC[i][5:0]));
      check(lock, VEC[i][8], $sformatf("R2/R3/R4/R6/R7 vector %0d", i));
      check(rf_en, VEC[i][8], $sformatf("R9 vector %0d", i));
    end

    // R5: locked, then a reference strobe with no feedback strobe
    precise = 1'b0;
    repeat (3) pd_cycle(1'b0, 1);
    check(lock, 1'b1, "R5 locked before saturation");
    @(negedge clk); ref_stb = 1'b1;
    @(negedge clk); ref_stb = 1'b0;
    repeat (61) @(negedge clk);
    check(lock, 1'b1, "R5 still locked just before limit");
    repeat (4) @(negedge clk);
    check(lock, 1'b0, "R5 saturation drops lock");

    // R8: partial run, power-down, then a full new run is needed
    repeat (2) pd_cycle(1'b0, 1);
    @(negedge clk); pwr_down = 1'b1;
    @(negedge clk);
    check(rf_en, 1'b0, "R8 rf_en off in power-down");
    pwr_down = 1'b0;
    pd_cycle(1'b0, 1);
    check(lock, 1'b0, "R8 run cleared by power-down (1)");
    pd_cycle(1'b0, 1);
    check(lock, 1'b0, "R8 run cleared by power-down (2)");
    pd_cycle(1'b0, 1);
    check(lock, 1'b1, "R8 relock after full run");
    @(negedge clk); pwr_down = 1'b1;
    @(negedge clk);
    check(lock, 1'b0, "R8 power-down clears lock");
    check(rf_en, 1'b0, "R9 rf_en off in power-down");

    // R10: mute disabled
    mute_en = 1'b0;
    @(negedge clk);
    check(rf_en, 1'b0, "R10 rf_en follows power-down");
    pwr_down = 1'b0;
    @(negedge clk);
    check(lock, 1'b0, "R10 still unlocked");
    check(rf_en, 1'b1, "R10 rf_en on while unlocked");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule